// File: doc/BRIEF.md
# IR wake pattern comparator

This block sits behind an infrared sampler that delivers run-length encoded bytes: bit 7 of each byte is the polarity (1 = carrier present, 0 = gap) and bits 6:0 are the length in sample periods. It has two modes. In learning mode it appends every arriving byte to an on-chip pattern store. In compare mode it leaves the store unchanged and matches each new byte against the stored pattern, one position at a time, within a programmed tolerance. When the programmed number of positions has matched in a row, it raises a match flag and pulses its wake output for one clock.

A small host register port configures the compare depth, the tolerance, the trigger level and the gap limit. The same port reports sticky status flags and lets the host walk through the stored pattern without removing it. A gap accumulator raises a packet-end flag once consecutive gap bytes add up to a 16-bit limit.

Top module: `ir_wake_matcher`

## Requirements
- R1: Register offsets: 0 control (bit 0 = compare mode, bit 1 = clear-pattern strobe), 1 status (bit 0 match, bit 1 packet end, bit 2 trigger reached, bit 3 overflow), 2 compare depth, 3 tolerance, 4 trigger level, 5/6 gap limit low/high byte, 7 stored count, 8 unread count, 9 pattern data. After reset the compare depth reads 65, the tolerance reads 4, the trigger level reads 67, and status, stored count, unread count and wake output are all zero.
- R2: In learning mode each valid sample byte is written into the store and the stored count grows by one.
- R3: A read of offset 9 returns the oldest unread stored byte, advances the read position and leaves the stored count unchanged. Offset 8 reads the number of unread bytes and is nonzero while any remain. A read of offset 9 with none left returns 0.
- R4: The clear strobe empties the store only when the mode held before that write is learning mode. In compare mode it has no effect on the stored count.
- R5: In compare mode sample bytes are never written to the store, so the stored count stays constant.
- R6: A live byte matches a stored byte when their polarity bits are equal and their 7-bit lengths differ by no more than the tolerance.
- R7: A mismatch returns the comparison to the first stored byte, and the mismatching byte is itself compared against that first byte.
- R8: When the number of consecutive matches reaches the compare depth, status bit 0 is set and wake_o is high for exactly the next cycle. A depth of 0, or a depth greater than the stored count, never produces a match.
- R9: Status bits are cleared by writing 1 to them. Writing 0 leaves them unchanged.
- R10: Gap byte lengths add up until the sum first reaches the gap limit, which sets status bit 1. A carrier byte restarts the sum.
- R11: In learning mode, status bit 2 is set when a write brings the stored count to the trigger level.
- R12: When the store is full, further learning bytes are dropped, the count stays at the store size, and status bit 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample byte valid for one cycle |
| smp_byte | input | 8 | Run-length byte: polarity in bit 7, length in bits 6:0 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances the pattern read position at offset 9) |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| wake_o | output | 1 | One-cycle wake request on a full match |

## Verification
The assertions assume that reset is asserted before the first sample, and that the store size is at most 255 so that every count fits in a byte register. The bound on the compare position relies on the host changing the depth or the mode only through register writes, because such a write restarts the comparison. The bench keeps within these assumptions. It presents at most one sample byte per cycle, reconfigures only between sequences, and steps through a tolerance and length-difference grid around a single stored byte.

// File: rtl/ir_wake_matcher.sv
module ir_wake_matcher #(
  parameter int          STORE     = 128,
  parameter logic [7:0]  DEPTH_RST = 8'd65,
  parameter logic [7:0]  TOL_RST   = 8'd4,
  parameter logic [7:0]  TRIG_RST  = 8'd67,
  parameter logic [15:0] LIMIT_RST = 16'd2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_valid,
  input  logic [7:0] smp_byte,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       wake_o
);

  localparam int AW = $clog2(STORE);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(STORE);

  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_STAT  = 4'd1;
  localparam logic [3:0] A_DEPTH = 4'd2;
  localparam logic [3:0] A_TOL   = 4'd3;
  localparam logic [3:0] A_TRIG  = 4'd4;
  localparam logic [3:0] A_LIMLO = 4'd5;
  localparam logic [3:0] A_LIMHI = 4'd6;
  localparam logic [3:0] A_CNT   = 4'd7;
  localparam logic [3:0] A_UNRD  = 4'd8;
  localparam logic [3:0] A_DATA  = 4'd9;

  logic [7:0]    mem [STORE];
  logic          cmp_mode;
  logic [7:0]    depth_q, tol_q, trig_q;
  logic [15:0]   limit_q;
  logic [3:0]    stat_q;
  logic [CW-1:0] cnt_q, rdp_q, cmp_idx, idx_n;
  logic [16:0]   acc_q, acc_sum;
  logic          wake_q, hit_done;

  function automatic logic near(input logic [7:0] a, input logic [7:0] b, input logic [7:0] t);
    logic [6:0] d;
    d = (a[6:0] > b[6:0]) ? a[6:0] - b[6:0] : b[6:0] - a[6:0];
    return (a[7] == b[7]) && ({1'b0, d} <= t);
  endfunction

  wire wr_ctrl  = reg_wr && reg_addr == A_CTRL;
  wire do_clear = wr_ctrl && reg_wdata[1] && !cmp_mode;
  wire learn_wr = smp_valid && !cmp_mode && !do_clear;
  wire has_room = cnt_q < FULL;
  wire pop      = reg_rd && reg_addr == A_DATA && rdp_q < cnt_q;
  wire cmp_ok   = depth_q != 8'd0 && int'(depth_q) <= int'(cnt_q);
  wire touch    = wr_ctrl || (reg_wr && reg_addr == A_DEPTH);
  wire hit_cur  = near(smp_byte, mem[cmp_idx[AW-1:0]], tol_q);
  wire hit_one  = near(smp_byte, mem[0], tol_q);

  assign acc_sum = acc_q + 17'(smp_byte[6:0]);
  wire   below   = acc_q < {1'b0, limit_q};
  wire   pe_hit  = smp_valid && !smp_byte[7] && below && acc_sum >= {1'b0, limit_q};
  wire   trig_hit = learn_wr && has_room && int'(cnt_q) + 1 == int'(trig_q);
  wire   ovf_hit  = learn_wr && !has_room;

  always_comb begin
    idx_n    = cmp_idx;
    hit_done = 1'b0;
    if (!cmp_mode || !cmp_ok || touch) begin
      idx_n = '0;
    end else if (smp_valid) begin
      if (hit_cur) begin
        if (int'(cmp_idx) + 1 == int'(depth_q)) begin
          idx_n    = '0;
          hit_done = 1'b1;
        end else begin
          idx_n = cmp_idx + 1'b1;
        end
      end else if (hit_one) begin
        if (depth_q == 8'd1) begin
          idx_n    = '0;
          hit_done = 1'b1;
        end else begin
          idx_n = CW'(1);
        end
      end else begin
        idx_n = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (learn_wr && has_room) mem[cnt_q[AW-1:0]] <= smp_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_mode <= 1'b0;
      depth_q  <= DEPTH_RST;
      tol_q    <= TOL_RST;
      trig_q   <= TRIG_RST;
      limit_q  <= LIMIT_RST;
      stat_q   <= '0;
      cnt_q    <= '0;
      rdp_q    <= '0;
      cmp_idx  <= '0;
      acc_q    <= '0;
      wake_q   <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL:  cmp_mode <= reg_wdata[0];
          A_DEPTH: depth_q <= reg_wdata;
          A_TOL:   tol_q <= reg_wdata;
          A_TRIG:  trig_q <= reg_wdata;
          A_LIMLO: limit_q[7:0] <= reg_wdata;
          A_LIMHI: limit_q[15:8] <= reg_wdata;
          default: ;
        endcase
      end

      if (do_clear) begin
        cnt_q <= '0;
        rdp_q <= '0;
      end else begin
        if (learn_wr && has_room) cnt_q <= cnt_q + 1'b1;
        if (pop) rdp_q <= rdp_q + 1'b1;
      end

      if (smp_valid) begin
        if (smp_byte[7]) acc_q <= '0;
        else if (below) acc_q <= acc_sum;
      end

      stat_q <= (stat_q & ~((reg_wr && reg_addr == A_STAT) ? reg_wdata[3:0] : 4'h0))
              | {ovf_hit, trig_hit, pe_hit, hit_done};

      cmp_idx <= idx_n;
      wake_q  <= hit_done;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {7'd0, cmp_mode};
      A_STAT:  reg_rdata = {4'd0, stat_q};
      A_DEPTH: reg_rdata = depth_q;
      A_TOL:   reg_rdata = tol_q;
      A_TRIG:  reg_rdata = trig_q;
      A_LIMLO: reg_rdata = limit_q[7:0];
      A_LIMHI: reg_rdata = limit_q[15:8];
      A_CNT:   reg_rdata = 8'(cnt_q);
      A_UNRD:  reg_rdata = 8'(cnt_q - rdp_q);
      A_DATA:  reg_rdata = (rdp_q < cnt_q) ? mem[rdp_q[AW-1:0]] : 8'h00;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign wake_o = wake_q;

endmodule

// File: rtl/ir_wake_matcher_chk.sv
module ir_wake_matcher_chk #(
  parameter int STORE = 128,
  parameter int CW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wake_o,
  input logic          cmp_mode,
  input logic [3:0]    stat_q,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] rdp_q,
  input logic [CW-1:0] cmp_idx,
  input logic [7:0]    depth_q
);

  a_r8_wake_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> stat_q[0]);

  a_r8_wake_from_compare: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(cmp_mode));

  a_r5_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmp_mode) |-> cnt_q == $past(cnt_q));

  a_r12_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= STORE);

  a_r3_read_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rdp_q <= cnt_q);

  a_r7_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_idx != '0) |-> int'(cmp_idx) < int'(depth_q));

endmodule

bind ir_wake_matcher ir_wake_matcher_chk #(.STORE(STORE), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wake_o(wake_o), .cmp_mode(cmp_mode),
  .stat_q(stat_q), .cnt_q(cnt_q), .rdp_q(rdp_q), .cmp_idx(cmp_idx),
  .depth_q(depth_q)
);

// File: tb/ir_wake_matcher_test.sv
`timescale 1ns/1ps
module ir_wake_matcher_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0;
  logic [7:0] smp_byte = 8'h00;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       wake_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ir_wake_matcher uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_byte(smp_byte),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake_o(wake_o)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic pop(output int v);
    @(negedge clk);
    reg_addr = 4'd9; reg_rd = 1'b1;
    #1;
    v = int'(reg_rdata);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    smp_valid = 1'b1; smp_byte = b;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd2, v); check("R1 depth", v, 65);
    rd(4'd3, v); check("R1 tol", v, 4);
    rd(4'd4, v); check("R1 trig", v, 67);
    rd(4'd1, v); check("R1 status", v, 0);
    rd(4'd7, v); check("R1 count", v, 0);
    rd(4'd8, v); check("R1 unread", v, 0);
    check("R1 wake", int'(wake_o), 0);

    // R2 learning
    send(8'h85); send(8'h10); send(8'h90);
    rd(4'd7, v); check("R2 count", v, 3);

    // R3 read-only walk
    rd(4'd8, v); check("R3 unread", v, 3);
    pop(v); check("R3 byte0", v, 8'h85);
    pop(v); check("R3 byte1", v, 8'h10);
    rd(4'd8, v); check("R3 unread mid", v, 1);
    pop(v); check("R3 byte2", v, 8'h90);
    rd(4'd8, v); check("R3 unread end", v, 0);
    pop(v); check("R3 empty read", v, 0);
    rd(4'd7, v); check("R3 count kept", v, 3);

    // R7 / R8 compare with restart
    wr(4'd2, 8'd3); wr(4'd3, 8'd0); wr(4'd0, 8'h01);
    send(8'h85); check("R7 w1", int'(wake_o), 0);
    send(8'h10); check("R7 w2", int'(wake_o), 0);
    send(8'h85); check("R7 restart", int'(wake_o), 0);
    send(8'h10); check("R7 w4", int'(wake_o), 0);
    send(8'h90); check("R8 wake", int'(wake_o), 1);
    rd(4'd1, v); check("R8 match flag", v & 1, 1);
    @(negedge clk); check("R8 pulse width", int'(wake_o), 0);
    rd(4'd7, v); check("R5 count frozen", v, 3);
    wr(4'd1, 8'h00); rd(4'd1, v); check("R9 write zero", v & 1, 1);
    wr(4'd1, 8'h01); rd(4'd1, v); check("R9 w1c", v & 1, 0);

    // R8 depth over count, and depth zero
    wr(4'd2, 8'd4);
    send(8'h85); send(8'h10); send(8'h90); send(8'h85);
    check("R8 depth>count", int'(wake_o), 0);
    rd(4'd1, v); check("R8 no flag", v & 1, 0);
    wr(4'd2, 8'd0);
    send(8'h85); check("R8 depth0", int'(wake_o), 0);

    // R4 clear gated by mode
    wr(4'd0, 8'h03); rd(4'd7, v); check("R4 clear ignored", v, 3);
    wr(4'd0, 8'h00); wr(4'd0, 8'h02); rd(4'd7, v); check("R4 clear", v, 0);

    // R6 tolerance sweep against one stored byte (polarity 1, length 40)
    send(8'hA8);
    wr(4'd2, 8'd1); wr(4'd0, 8'h01);
    for (int t = 0; t < 4; t++) begin
      wr(4'd3, 8'(t));
      for (int d = -5; d <= 5; d++) begin
        for (int p = 0; p < 2; p++) begin
          send({p[0], 7'(40 + d)});
          check($sformatf("R6 t%0d d%0d p%0d", t, d, p), int'(wake_o),
                (p == 1 && (d < 0 ? -d : d) <= t) ? 1 : 0);
        end
      end
    end

    // R10 packet end from gap sum
    wr(4'd5, 8'd100); wr(4'd6, 8'd0);
    send(8'h81);
    wr(4'd1, 8'h0F);
    send(8'h30); rd(4'd1, v); check("R10 below a", (v >> 1) & 1, 0);
    send(8'h30); rd(4'd1, v); check("R10 below b", (v >> 1) & 1, 0);
    send(8'h05); rd(4'd1, v); check("R10 reach", (v >> 1) & 1, 1);
    wr(4'd1, 8'h02);
    send(8'h05); rd(4'd1, v); check("R10 once", (v >> 1) & 1, 0);
    send(8'h81); send(8'h64); rd(4'd1, v); check("R10 restart", (v >> 1) & 1, 1);

    // R11 trigger level, R12 overflow
    wr(4'd0, 8'h00); wr(4'd0, 8'h02); wr(4'd1, 8'h0F);
    for (int i = 0; i < 66; i++) send(8'h80 | 8'(i & 8'h3F));
    rd(4'd1, v); check("R11 before", (v >> 2) & 1, 0);
    send(8'h81);
    rd(4'd1, v); check("R11 reach", (v >> 2) & 1, 1);
    for (int i = 67; i < 128; i++) send(8'h82);
    rd(4'd7, v); check("R12 full count", v, 128);
    rd(4'd1, v); check("R12 no ovf yet", (v >> 3) & 1, 0);
    send(8'h83); send(8'h84);
    rd(4'd7, v); check("R12 count held", v, 128);
    rd(4'd1, v); check("R12 ovf", (v >> 3) & 1, 1);

    finish_run();
  end
endmodule